// File: doc/BRIEF.md
# Centralized Bus Arbiter With Anti-Starvation Promotion

This block gives a shared bus to one of several masters. Each master drives its own request line into the arbiter and gets back its own grant line. When the bus is free the arbiter picks one requester on the next clock edge. The master holding the grant keeps it until it pulses the common release input. After a release the bus stays empty for one cycle, and then it is arbitrated again.

By default the choice follows a fixed order, and the master on bit 0 ranks first. The arbiter keeps an age count for each master. The count goes up every time the bus is awarded to some other master while this one is still requesting. When the count reaches a set limit, that request is promoted and ranks above every request that has not been promoted. This puts a bound on how long even the lowest-ranked master can wait.

Top module: `bus_arbiter`

## Requirements
- R1: While rst_ni is low, gnt_o is all zeros.
- R2: No more than one bit of gnt_o is high in any cycle.
- R3: When no request is promoted, the lowest-numbered bit of req_i wins. Bit 0 has the highest rank.
- R4: When the bus is free and req_i is not zero at a clock edge, gnt_o is one-hot from that edge on, with no extra cycle of latency.
- R5: A grant stays unchanged while release_i is low. This holds even when other requests change or the owner drops its own request.
- R6: A release_i that is high at an edge while a grant is held clears gnt_o at that edge, even if the owner is still requesting. At the following edge arbitration runs again.
- R7: When req_i is zero the bus stays free. A release_i while the bus is free has no effect.
- R8: Each time the bus is awarded to another master, the age of a requesting master goes up by one, and it saturates at AGE_LIMIT. At AGE_LIMIT the request ranks above all requests that are not promoted.
- R9: When several requests are promoted, the lowest-numbered one wins.
- R10: A master's age goes back to zero when it is granted or when its request is low at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MASTERS | One request line per master; bit 0 ranks highest |
| release_i | input | 1 | The current owner gives up the bus |
| gnt_o | output | N_MASTERS | One-hot grant to the current owner, or zero when the bus is free |

## Verification
The bench uses the default build: four masters and an age limit of 8. With these values, three masters requesting against a master that keeps winning produce promotion after eight awards. Two requests reach the limit on the same award, so both the tie between promoted requests and the saturation of a waiting count can be seen within about ten grants. A separate run withdraws a request that has already aged, to show that its age starts again from zero.

// File: rtl/arb_pkg.sv
package arb_pkg;
  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/arb_pick.sv
// Lowest set bit wins.
module arb_pick #(
  parameter int unsigned WIDTH = 4,
  localparam int unsigned IW = arb_pkg::idx_width(WIDTH)
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [IW-1:0]    idx_o,
  output logic             vld_o
);
  always_comb begin
    idx_o = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign vld_o = |vec_i;
endmodule

// File: rtl/arb_age_cnt.sv
module arb_age_cnt #(
  parameter int unsigned AGE_LIMIT = 8,
  localparam int unsigned AW = $clog2(AGE_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic award_i,
  input  logic won_i,
  output logic promoted_o
);
  logic [AW-1:0] age_q, age_d;

  always_comb begin
    age_d = age_q;
    if (!req_i || (award_i && won_i)) age_d = '0;
    else if (award_i && age_q < AW'(AGE_LIMIT)) age_d = age_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else         age_q <= age_d;
  end

  assign promoted_o = (age_q == AW'(AGE_LIMIT));

  assert_age_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q <= AW'(AGE_LIMIT));
  assert_age_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || (award_i && won_i)) |=> (age_q == '0));
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int unsigned N_MASTERS = 4,
  parameter int unsigned AGE_LIMIT = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic                 release_i,
  output logic [N_MASTERS-1:0] gnt_o
);
  localparam int unsigned IW = arb_pkg::idx_width(N_MASTERS);

  logic [N_MASTERS-1:0] gnt_q, gnt_d, promoted, win_oh;
  logic [IW-1:0]        fix_idx, old_idx, win_idx;
  logic                 fix_vld, old_vld, busy, award;

  arb_pick #(.WIDTH(N_MASTERS)) u_pick_fixed (
    .vec_i(req_i), .idx_o(fix_idx), .vld_o(fix_vld));
  arb_pick #(.WIDTH(N_MASTERS)) u_pick_aged (
    .vec_i(req_i & promoted), .idx_o(old_idx), .vld_o(old_vld));

  assign busy    = |gnt_q;
  assign award   = !busy && fix_vld;
  assign win_idx = old_vld ? old_idx : fix_idx;

  always_comb begin
    win_oh = '0;
    win_oh[win_idx] = 1'b1;
  end

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_age
    arb_age_cnt #(.AGE_LIMIT(AGE_LIMIT)) u_age (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req_i[g]),
      .award_i   (award),
      .won_i     (win_oh[g]),
      .promoted_o(promoted[g])
    );
  end

  always_comb begin
    gnt_d = gnt_q;
    if (busy && release_i) gnt_d = '0;
    else if (award)        gnt_d = win_oh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= '0;
    else         gnt_q <= gnt_d;
  end

  assign gnt_o = gnt_q;

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (gnt_o == '0));
  assert_single_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_grant_to_requester_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o == '0) && (req_i != '0)) |=> ((gnt_o & $past(req_i)) != '0));
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o != '0) && !release_i) |=> $stable(gnt_o));
  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o != '0) && release_i) |=> (gnt_o == '0));
  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o == '0) && (req_i == '0)) |=> (gnt_o == '0));
endmodule

// File: tb/bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module bus_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic       rel = 1'b0;
  logic [3:0] gnt;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_arbiter #(.N_MASTERS(4), .AGE_LIMIT(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .release_i(rel), .gnt_o(gnt));

  function automatic int oh2idx(logic [3:0] g);
    case (g)
      4'b0000: return -1;
      4'b0001: return 0;
      4'b0010: return 1;
      4'b0100: return 2;
      4'b1000: return 3;
      default: return -2;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // wait for a grant, check its owner, release, check the bus is freed
  task automatic serve(int exp, string tag);
    int n = 0;
    while (gnt == '0 && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(oh2idx(gnt) == exp, tag, oh2idx(gnt), exp);
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
    chk(gnt == '0, "R6 release frees bus", oh2idx(gnt), -1);
  endtask

  task automatic go_idle();
    req = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    req = 4'b1111;
    repeat (3) @(negedge clk);
    chk(gnt == '0, "R1 reset", oh2idx(gnt), -1);
    req = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(gnt == '0, "R7 idle after reset", oh2idx(gnt), -1);
  endtask

  task automatic t_latency();
    req = 4'b0100;
    @(negedge clk);
    chk(gnt == 4'b0100, "R4 one edge latency", oh2idx(gnt), 2);
    serve(2, "R4 owner");
    go_idle();
  endtask

  task automatic t_priority();
    req = 4'b1110;
    serve(1, "R3 priority 1110");
    req = 4'b1100;
    serve(2, "R3 priority 1100");
    go_idle();
    req = 4'b1010;
    serve(1, "R3 priority 1010");
    go_idle();
    req = 4'b1111;
    serve(0, "R3 priority 1111");
    go_idle();
  endtask

  task automatic t_hold();
    req = 4'b1000;
    serve_wait();
    chk(gnt == 4'b1000, "R5 owner", oh2idx(gnt), 3);
    req = 4'b0111;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(gnt == 4'b1000, "R5 hold", oh2idx(gnt), 3);
      chk($countones(gnt) <= 1, "R2 single grant", $countones(gnt), 1);
    end
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
    chk(gnt == '0, "R6 release", oh2idx(gnt), -1);
    @(negedge clk);
    chk(gnt == 4'b0001, "R6 rearbitrate", oh2idx(gnt), 0);
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
    go_idle();
  endtask

  task automatic serve_wait();
    int n = 0;
    while (gnt == '0 && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reclaim();
    req = 4'b0001;
    serve(0, "R6 first grant");
    @(negedge clk);
    chk(gnt == 4'b0001, "R6 owner regains after idle cycle", oh2idx(gnt), 0);
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
    go_idle();
  endtask

  task automatic t_idle_release();
    rel = 1'b1;
    repeat (2) @(negedge clk);
    chk(gnt == '0, "R7 release while idle", oh2idx(gnt), -1);
    rel = 1'b0;
    @(negedge clk);
    chk(gnt == '0, "R7 no request", oh2idx(gnt), -1);
    req = 4'b0010;
    @(negedge clk);
    chk(gnt == 4'b0010, "R7 later request granted", oh2idx(gnt), 1);
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
    go_idle();
  endtask

  task automatic t_starve();
    req = 4'b1011;
    for (int i = 0; i < 8; i++) serve(0, "R8 fixed winner before limit");
    serve(1, "R9 lowest promoted wins");
    serve(3, "R8 saturated promoted served");
    serve(0, "R8 back to fixed order");
    go_idle();
  endtask

  task automatic t_age_reset();
    req = 4'b1001;
    for (int i = 0; i < 5; i++) serve(0, "R10 build age");
    go_idle();
    req = 4'b1001;
    for (int i = 0; i < 8; i++) serve(0, "R10 age restarted");
    serve(3, "R10 promoted after full wait");
    go_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_latency();
    t_priority();
    t_hold();
    t_reclaim();
    t_idle_release();
    t_starve();
    t_age_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule